// File: doc/BRIEF.md
# Partitioned Cache Victim Way Selector

This block chooses which way of a set-associative cache receives a new line after a miss, in a cache whose ways are divided among resource-control IDs. Each pair of requester ID and access type owns a way mask and an optional occupancy limit, both held in a small configuration table inside the block. On a miss the cache presents the requester's ID, access type, set index and current line count, together with the valid bits and owner IDs of the indexed set. One cycle later the block returns a victim way and a valid flag. A low flag means the fill is bypassed.

Hit lookup does not pass through this block. A hit is served from whichever way holds the line, whoever's allocation that way belongs to. The block only limits where new lines may be placed. A requester can therefore evict lines only inside its own ways. Masks may overlap, and a way that appears in several masks is shared.

When no limit applies, the block fills an invalid allowed way first. If every allowed way is valid, it rotates through the allowed ways using a pointer kept for each set. When the requester has reached a non-zero limit, it may only replace a line it already owns inside its allowed ways.

Top module: `victim_way_sel`

## Requirements
- R1: After reset, vic_valid is 0. The table gives ID 0 an all-ones way mask with limit 0 for every access type. Every other ID gets an all-zero mask with limit 0. Every set's rotation pointer starts at NUM_WAYS-1.
- R2: A valid victim is always a way whose bit is set in the mask of the requesting (ID, access type) pair.
- R3: Masks of different IDs may overlap, and each ID may select a shared way.
- R4: A limit of 0 means no limit, whatever the value of req_occ.
- R5: When the limit is non-zero and req_occ >= limit, the victim is the first way after the set's pointer that meets three conditions: it is allowed, valid, and its owner field (set_owner bits [w*ID_W +: ID_W]) equals req_id. Invalid ways are not used. If no way qualifies, vic_valid is 0.
- R6: When not limited and an allowed way has set_valid low, the victim is the lowest-indexed such way. The pointer is left unchanged.
- R7: When not limited and every allowed way is valid, the victim is the first allowed way found by searching upward from pointer+1, wrapping modulo NUM_WAYS. The set's pointer is then set to that way. Pointers change only on such rotation picks, including limited picks.
- R8: An all-zero mask produces no victim and leaves every pointer unchanged.
- R9: vic_valid and vic_way are registered. They reflect the request strobed in the previous cycle. Without a strobe, vic_valid is 0 and vic_way is 0. vic_way is 0 whenever vic_valid is 0.
- R10: A cfg_we write replaces the mask and limit of the (cfg_id, cfg_at) entry and no other entry. A request in the same cycle still sees the old entry. Requests from the next cycle see the new one.
- R11: The access type selects the entry, so one ID may have different masks for different access types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the table entry |
| cfg_id | input | ID_W | ID of the entry written |
| cfg_at | input | AT_W | Access type of the entry written |
| cfg_mask | input | NUM_WAYS | New way mask |
| cfg_limit | input | OCC_W | New occupancy limit (0 = none) |
| req_valid | input | 1 | Miss fill request strobe |
| req_id | input | ID_W | Requester ID |
| req_at | input | AT_W | Requester access type |
| req_set | input | SET_W | Set index of the miss |
| req_occ | input | OCC_W | Lines currently held by the requester |
| set_valid | input | NUM_WAYS | Valid bit of each way in the set |
| set_owner | input | NUM_WAYS*ID_W | Owner ID of each way, way w at bits [w*ID_W +: ID_W] |
| vic_valid | output | 1 | Victim produced for the previous request |
| vic_way | output | WAY_W | Chosen victim way |

## Verification
The assertions assume that req_id, req_at, set_valid and set_owner are stable and known in every cycle where req_valid is high, and that reset is released away from a clock edge. The bench changes every input only at the falling clock edge and holds it for a whole cycle. It also writes the table only through cfg_we, so the mask seen by each request is always a defined register value.

// File: rtl/vws_pkg.sv
package vws_pkg;
    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_FREE = 2'd1,
        PK_ROT  = 2'd2
    } pick_kind_e;
endpackage

// File: rtl/vws_cfg_table.sv
module vws_cfg_table #(
    parameter int ID_W     = 2,
    parameter int AT_W     = 2,
    parameter int NUM_WAYS = 8,
    parameter int OCC_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ID_W-1:0]     wr_id,
    input  logic [AT_W-1:0]     wr_at,
    input  logic [NUM_WAYS-1:0] wr_mask,
    input  logic [OCC_W-1:0]    wr_limit,
    input  logic [ID_W-1:0]     rd_id,
    input  logic [AT_W-1:0]     rd_at,
    output logic [NUM_WAYS-1:0] rd_mask,
    output logic [OCC_W-1:0]    rd_limit
);
    localparam int ENTRIES = 1 << (ID_W + AT_W);
    localparam int NUM_AT  = 1 << AT_W;

    typedef struct packed {
        logic [NUM_WAYS-1:0] mask;
        logic [OCC_W-1:0]    limit;
    } entry_t;

    entry_t tab_q [ENTRIES];
    entry_t tab_d [ENTRIES];

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[{wr_id, wr_at}] = '{mask: wr_mask, limit: wr_limit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i].mask  <= (i < NUM_AT) ? {NUM_WAYS{1'b1}} : {NUM_WAYS{1'b0}};
                tab_q[i].limit <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_mask  = tab_q[{rd_id, rd_at}].mask;
    assign rd_limit = tab_q[{rd_id, rd_at}].limit;
endmodule

// File: rtl/vws_rr_ptrs.sv
module vws_rr_ptrs #(
    parameter int SET_W    = 4,
    parameter int NUM_WAYS = 8,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_ptr
);
    localparam int NUM_SETS = 1 << SET_W;

    logic [WAY_W-1:0] ptr_q [NUM_SETS];
    logic [WAY_W-1:0] ptr_d [NUM_SETS];

    always_comb begin
        ptr_d = ptr_q;
        if (upd_en) begin
            ptr_d[upd_set] = upd_way;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                ptr_q[s] <= WAY_W'(NUM_WAYS - 1);
            end
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign rd_ptr = ptr_q[rd_set];
endmodule

// File: rtl/vws_pick.sv
module vws_pick
    import vws_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int ID_W     = 2,
    parameter int OCC_W    = 8,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]      allow,
    input  logic [OCC_W-1:0]         limit,
    input  logic [OCC_W-1:0]         occ,
    input  logic [ID_W-1:0]          id,
    input  logic [NUM_WAYS-1:0]      line_valid,
    input  logic [NUM_WAYS*ID_W-1:0] line_owner,
    input  logic [WAY_W-1:0]         ptr,
    output pick_kind_e               kind,
    output logic [WAY_W-1:0]         way,
    output logic                     limited
);
    logic [NUM_WAYS-1:0] owned;
    logic [NUM_WAYS-1:0] free_ways;
    logic [NUM_WAYS-1:0] rot_cand;
    logic [WAY_W-1:0]    free_way;
    logic [WAY_W-1:0]    rot_way;
    logic                rot_hit;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_own
        assign owned[w] = line_valid[w] && (line_owner[w*ID_W +: ID_W] == id);
    end

    assign limited   = (limit != '0) && (occ >= limit);
    assign free_ways = allow & ~line_valid;
    assign rot_cand  = limited ? (allow & owned) : allow;

    always_comb begin
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (free_ways[w]) free_way = WAY_W'(w);
        end
    end

    always_comb begin
        logic [WAY_W:0] t;
        rot_hit = 1'b0;
        rot_way = '0;
        for (int k = NUM_WAYS; k >= 1; k--) begin
            t = {1'b0, ptr} + (WAY_W+1)'(k);
            if (t >= (WAY_W+1)'(NUM_WAYS)) t = t - (WAY_W+1)'(NUM_WAYS);
            if (rot_cand[t[WAY_W-1:0]]) begin
                rot_hit = 1'b1;
                rot_way = t[WAY_W-1:0];
            end
        end
    end

    always_comb begin
        if (!limited && (free_ways != '0)) begin
            kind = PK_FREE;
            way  = free_way;
        end else if (rot_hit) begin
            kind = PK_ROT;
            way  = rot_way;
        end else begin
            kind = PK_NONE;
            way  = '0;
        end
    end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
    import vws_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int ID_W     = 2,
    parameter int AT_W     = 2,
    parameter int SET_W    = 4,
    parameter int OCC_W    = 8,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ID_W-1:0]          cfg_id,
    input  logic [AT_W-1:0]          cfg_at,
    input  logic [NUM_WAYS-1:0]      cfg_mask,
    input  logic [OCC_W-1:0]         cfg_limit,
    input  logic                     req_valid,
    input  logic [ID_W-1:0]          req_id,
    input  logic [AT_W-1:0]          req_at,
    input  logic [SET_W-1:0]         req_set,
    input  logic [OCC_W-1:0]         req_occ,
    input  logic [NUM_WAYS-1:0]      set_valid,
    input  logic [NUM_WAYS*ID_W-1:0] set_owner,
    output logic                     vic_valid,
    output logic [WAY_W-1:0]         vic_way
);
    typedef struct packed {
        logic             valid;
        logic [WAY_W-1:0] way;
    } out_t;

    out_t st_d, st_q;

    logic [NUM_WAYS-1:0] allow_mask;
    logic [OCC_W-1:0]    occ_limit;
    logic [WAY_W-1:0]    rot_ptr;
    pick_kind_e          pick_kind;
    logic [WAY_W-1:0]    pick_way;
    logic                pick_limited;
    logic                pick_ok;
    logic                ptr_upd;

    vws_cfg_table #(.ID_W(ID_W), .AT_W(AT_W), .NUM_WAYS(NUM_WAYS), .OCC_W(OCC_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_id(cfg_id), .wr_at(cfg_at),
        .wr_mask(cfg_mask), .wr_limit(cfg_limit),
        .rd_id(req_id), .rd_at(req_at),
        .rd_mask(allow_mask), .rd_limit(occ_limit)
    );

    vws_rr_ptrs #(.SET_W(SET_W), .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .upd_en(ptr_upd), .upd_set(req_set), .upd_way(pick_way),
        .rd_set(req_set), .rd_ptr(rot_ptr)
    );

    vws_pick #(.NUM_WAYS(NUM_WAYS), .ID_W(ID_W), .OCC_W(OCC_W), .WAY_W(WAY_W)) u_pick (
        .allow(allow_mask), .limit(occ_limit), .occ(req_occ), .id(req_id),
        .line_valid(set_valid), .line_owner(set_owner), .ptr(rot_ptr),
        .kind(pick_kind), .way(pick_way), .limited(pick_limited)
    );

    assign pick_ok = (pick_kind != PK_NONE);
    assign ptr_upd = req_valid && (pick_kind == PK_ROT);

    always_comb begin
        st_d.valid = req_valid && pick_ok;
        st_d.way   = st_d.valid ? pick_way : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vic_valid = st_q.valid;
    assign vic_way   = st_q.way;

    a_r2_victim_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pick_ok) |-> allow_mask[pick_way]);

    a_r5_limited_own_line: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pick_ok && pick_limited) |->
        (set_valid[pick_way] && set_owner[pick_way*ID_W +: ID_W] == req_id));

    a_r6_free_before_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pick_ok && !pick_limited && (allow_mask & ~set_valid) != '0)
        |-> !set_valid[pick_way]);

    a_r8_empty_mask_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && allow_mask == '0) |=> !vic_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!vic_valid && vic_way == '0));
endmodule

// File: tb/victim_way_sel_bench.sv
`timescale 1ns/1ps
module victim_way_sel_bench;
    localparam int NW = 8, IDW = 2, ATW = 2, SW = 4, OW = 8, WW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we; logic [IDW-1:0] cfg_id; logic [ATW-1:0] cfg_at;
    logic [NW-1:0] cfg_mask; logic [OW-1:0] cfg_limit;
    logic req_valid; logic [IDW-1:0] req_id; logic [ATW-1:0] req_at;
    logic [SW-1:0] req_set; logic [OW-1:0] req_occ;
    logic [NW-1:0] set_valid; logic [NW*IDW-1:0] set_owner;
    logic vic_valid; logic [WW-1:0] vic_way;

    always #2 clk = ~clk;

    victim_way_sel u_victim_way_sel (.*);

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";
    int m_mask [4][4];
    int m_lim  [4][4];
    int m_ptr  [16];
    int own [8];
    int nxt_v, nxt_w, exp_v, exp_w;
    int pend_rot, pend_set, pend_way;
    int pend_cfg, pc_id, pc_at, pc_mask, pc_lim;
    int seed = 12345;

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fffff;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        exp_v = nxt_v; exp_w = nxt_w;
        if (pend_rot != 0) m_ptr[pend_set] = pend_way;
        if (pend_cfg != 0) begin m_mask[pc_id][pc_at] = pc_mask; m_lim[pc_id][pc_at] = pc_lim; end
        @(negedge clk);
        checks++;
        if (vic_valid !== exp_v[0] || vic_way !== WW'(exp_w)) begin
            fails++;
            $display("FAIL %s: vic_valid=%0d vic_way=%0d expected valid=%0d way=%0d",
                     tag, vic_valid, vic_way, exp_v, exp_w);
        end
        req_valid = 0; cfg_we = 0; nxt_v = 0; nxt_w = 0; pend_rot = 0; pend_cfg = 0;
    endtask

    task automatic cfg(int id, int at, int mask, int lim);
        cfg_we = 1; cfg_id = IDW'(id); cfg_at = ATW'(at);
        cfg_mask = NW'(mask); cfg_limit = OW'(lim);
        pend_cfg = 1; pc_id = id; pc_at = at; pc_mask = mask & 255; pc_lim = lim & 255;
    endtask

    // lines: valid bits plus owner of each way taken from own[]
    task automatic lines(int vbits);
        set_valid = NW'(vbits);
        for (int w = 0; w < NW; w++) set_owner[w*IDW +: IDW] = IDW'(own[w]);
    endtask

    // behavioural expectation from the requirement text
    task automatic req(int id, int at, int set, int occ);
        int mask, lim, lim_hit, found;
        req_valid = 1; req_id = IDW'(id); req_at = ATW'(at);
        req_set = SW'(set); req_occ = OW'(occ);
        mask = m_mask[id][at]; lim = m_lim[id][at];
        lim_hit = (lim != 0 && occ >= lim) ? 1 : 0;
        found = 0;
        if (lim_hit == 0) begin
            for (int w = 0; w < NW; w++)
                if (found == 0 && mask[w] && !set_valid[w]) begin found = 1; nxt_w = w; end
        end
        if (found == 0) begin
            for (int off = 1; off <= NW; off++) begin
                int w;
                w = (m_ptr[set] + off) % NW;
                if (found == 0 && mask[w] &&
                    (lim_hit == 0 || (set_valid[w] && own[w] == id))) begin
                    found = 1; nxt_w = w; pend_rot = 1; pend_set = set; pend_way = w;
                end
            end
        end
        nxt_v = found;
        if (found == 0) nxt_w = 0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        cfg_we = 0; cfg_id = 0; cfg_at = 0; cfg_mask = 0; cfg_limit = 0;
        req_valid = 0; req_id = 0; req_at = 0; req_set = 0; req_occ = 0;
        set_valid = 0; set_owner = 0;
        nxt_v = 0; nxt_w = 0; pend_rot = 0; pend_cfg = 0;
        for (int i = 0; i < 4; i++) for (int a = 0; a < 4; a++) begin
            m_mask[i][a] = (i == 0) ? 255 : 0; m_lim[i][a] = 0;
        end
        for (int s = 0; s < 16; s++) m_ptr[s] = NW - 1;
        for (int w = 0; w < NW; w++) own[w] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        tag = "R1"; tick();                               // reset state: no victim
        tag = "R1"; lines(255); req(0, 3, 0, 0); tick();  // ID 0 owns all ways: way 0
        tag = "R7"; req(0, 3, 0, 0); tick();              // rotation: way 1
        tag = "R1"; req(1, 0, 0, 0); tick();              // other IDs start with no ways
        tag = "R6"; lines(8'b1110_0101); req(0, 0, 2, 0); tick(); // lowest free: way 1
        tag = "R10"; cfg(1, 0, 8'b0011_0000, 0); lines(255); req(1, 0, 5, 0); tick(); // old entry
        tag = "R10"; req(1, 0, 5, 0); tick();             // way 4
        tag = "R7"; req(1, 0, 5, 0); tick();              // way 5
        tag = "R7"; req(1, 0, 5, 0); tick();              // wrap to way 4
        tag = "R11"; req(1, 1, 5, 0); tick();             // other access type still empty
        tag = "R3"; cfg(2, 0, 8'b0011_1100, 0); tick();
        tag = "R3"; req(2, 0, 5, 0); tick();              // shared way 5 after pointer 4
        tag = "R4"; req(1, 0, 6, 255); tick();            // limit 0: unlimited
        tag = "R5"; cfg(1, 0, 8'hF0, 2); tick();
        own[4] = 1; own[5] = 0; own[6] = 1; own[7] = 3;
        tag = "R5"; lines(8'b0111_0000); req(1, 0, 7, 2); tick(); // limited: own way 4
        tag = "R5"; lines(8'b0111_0000); req(1, 0, 7, 3); tick(); // own way 6
        tag = "R5"; lines(8'b0111_0000); req(1, 0, 7, 1); tick(); // below limit: free way 7
        own[4] = 2; own[6] = 2;
        tag = "R5"; lines(8'b1111_0000); req(1, 0, 7, 2); tick(); // none owned: dropped
        tag = "R8"; req(3, 2, 7, 0); tick();              // empty mask
        tag = "R8"; own[4] = 1; lines(255); req(1, 0, 7, 5); tick(); // pointer untouched by R8
        tag = "R9"; tick();
        tag = "R9";
        for (int n = 0; n < 600; n++) begin
            int r;
            r = rnd();
            if (r % 5 == 0) cfg(rnd() % 4, rnd() % 4, rnd() % 256, rnd() % 4);
            if (r % 7 != 3) begin
                for (int w = 0; w < NW; w++) own[w] = rnd() % 4;
                lines((r % 3 == 0) ? rnd() % 256 : 255);
                req(rnd() % 4, rnd() % 4, rnd() % 4, rnd() % 5);
            end
            tick();
        end
        finish_run();
    end
endmodule